// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Generator

This block holds two independent one-shot channels, all on one system clock. Each channel has three control inputs:

- an active-low trigger, which fires on its falling edge;
- an active-high trigger, which fires on its rising edge;
- an active-low clear.

Each channel drives a pulse output and its complement. A trigger is valid only under these conditions. The falling-edge trigger needs the rising-edge input high. The rising-edge trigger needs the falling-edge input low. The clear must be released in both cases. Releasing the clear while the falling-edge input is low and the rising-edge input is high also starts a pulse.

The pulse length is a number of clock cycles taken from a per-channel width input. This count replaces the external timing network of a discrete one-shot. A valid trigger that arrives during a pulse reloads the full count, so the output stays high until the width has run out after the most recent trigger. Every control input passes through a two-flop synchronizer. Edges are detected on the synchronized values.

Latency is fixed. If an input change is applied before clock edge k, its effect appears on the outputs right after edge k+2.

Top module: `dual_oneshot`

## Requirements
- R1: After asynchronous reset every pulse output is low and every complement output is high.
- R2: While a channel's clear input is low, its pulse output is low, whatever its trigger inputs do.
- R3: While the falling-edge trigger input (trig_fall_ni bit) is high, the channel accepts no trigger.
- R4: While the rising-edge trigger input (trig_rise_i bit) is low, the channel accepts no trigger.
- R5: A falling edge on trig_fall_ni, while trig_rise_i and clr_ni are high, produces a high pulse of exactly W cycles, where W is the channel's 16-bit width field. The pulse starts two cycles after the edge is sampled.
- R6: A rising edge on trig_rise_i, while trig_fall_ni is low and clr_ni is high, produces the same W-cycle pulse.
- R7: A rising edge on clr_ni, while trig_fall_ni is low and trig_rise_i is high, produces the same W-cycle pulse.
- R8: A valid trigger during a pulse reloads the count, so the pulse ends W cycles after the last trigger.
- R9: A width value of zero makes a trigger produce no pulse.
- R10: Clear going low during a pulse ends it with the fixed latency. A trigger edge that arrives in the same cycle as clear going low produces no pulse.
- R11: pulse_no is always the bitwise complement of pulse_o.
- R12: The channels are independent. Channel c uses width_i[c*16 +: 16] and bit c of each control input, and activity on one channel leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_fall_ni | input | NUM_CH | Falling-edge trigger, one bit per channel |
| trig_rise_i | input | NUM_CH | Rising-edge trigger, one bit per channel |
| clr_ni | input | NUM_CH | Clear, active low; its release acts as a trigger |
| width_i | input | NUM_CH*CNT_W | Pulse width in clock cycles, one field per channel |
| pulse_o | output | NUM_CH | Pulse output per channel |
| pulse_no | output | NUM_CH | Complement of pulse_o |

## Verification
The bench retriggers a channel after the pulse has already started. It checks that the output stays high past the first interval. A design that ignored the retrigger, or kept counting from the old value, would drop the pulse three cycles early.

Clear is tested in two ways. First it is lowered in the middle of a pulse. Then it is lowered in the same cycle as a trigger edge. A design that gave the trigger priority would leave a stray pulse.

Release of clear is tested as a trigger, and the blocking levels on each trigger input are toggled. A zero width and one channel clearing while the other pulses cover wrong gating, a missing reload value and crossed channel wiring.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic fall_n;
    logic rise;
    logic clr_n;
  } trig_lvl_t;

  localparam int unsigned TRIG_LVL_W = $bits(trig_lvl_t);
  // Reset level: no trigger armed, clear released, so reset produces no edge.
  localparam trig_lvl_t TRIG_IDLE = '{fall_n: 1'b1, rise: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
  import oneshot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trig_lvl_t lvl_i,
  output logic      fire_o,
  output logic      kill_o
);
  trig_lvl_t prev_q;
  logic fall_edge, rise_edge, clr_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= TRIG_IDLE;
    else         prev_q <= lvl_i;
  end

  assign fall_edge = prev_q.fall_n & ~lvl_i.fall_n;
  assign rise_edge = ~prev_q.rise & lvl_i.rise;
  assign clr_edge  = ~prev_q.clr_n & lvl_i.clr_n;

  // Clear has priority: no trigger is decoded while clear is asserted.
  assign kill_o = ~lvl_i.clr_n;
  assign fire_o = lvl_i.clr_n &
                  ((fall_edge & lvl_i.rise) |
                   (rise_edge & ~lvl_i.fall_n) |
                   (clr_edge  & ~lvl_i.fall_n & lvl_i.rise));

  a_r3_fall_high_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i.fall_n |-> !fire_o);
  a_r4_rise_low_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i.rise |-> !fire_o);
  a_r10_clear_excludes_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> !fire_o);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             q_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             q_q;

  always_comb begin
    cnt_d = cnt_q;
    if (kill_i)             cnt_d = '0;
    else if (fire_i)        cnt_d = width_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= (cnt_d != '0);
    end
  end

  assign q_o = q_q;

  a_r10_clear_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !q_o);
  a_r9_zero_width_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !kill_i && (width_i == '0) |=> !q_o);
  a_r8_trigger_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !kill_i && (width_i != '0) |=> q_o);
  a_r8_pulse_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o && (cnt_q > 1) && !kill_i |=> q_o);
endmodule

// File: rtl/oneshot_chan.sv
module oneshot_chan
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_ni,
  input  logic             rise_i,
  input  logic             clr_ni,
  input  logic [CNT_W-1:0] width_i,
  output logic             q_o,
  output logic             q_no
);
  trig_lvl_t raw_lvl, sync_lvl;
  logic      fire, kill, q;

  assign raw_lvl = '{fall_n: fall_ni, rise: rise_i, clr_n: clr_ni};

  oneshot_sync #(
    .W(TRIG_LVL_W), .STAGES(SYNC_STAGES), .RST_VAL(TRIG_IDLE)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_lvl), .q_o(sync_lvl)
  );

  oneshot_trig u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl),
    .fire_o(fire), .kill_o(kill)
  );

  oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .kill_i(kill),
    .width_i(width_i), .q_o(q)
  );

  assign q_o  = q;
  assign q_no = ~q;
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         trig_fall_ni,
  input  logic [NUM_CH-1:0]         trig_rise_i,
  input  logic [NUM_CH-1:0]         clr_ni,
  input  logic [NUM_CH*CNT_W-1:0]   width_i,
  output logic [NUM_CH-1:0]         pulse_o,
  output logic [NUM_CH-1:0]         pulse_no
);
  localparam int unsigned WBUS_W = NUM_CH * CNT_W;

  logic [WBUS_W-1:0] width_bus;
  assign width_bus = width_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    oneshot_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fall_ni (trig_fall_ni[c]),
      .rise_i  (trig_rise_i[c]),
      .clr_ni  (clr_ni[c]),
      .width_i (width_bus[c*CNT_W +: CNT_W]),
      .q_o     (pulse_o[c]),
      .q_no    (pulse_no[c])
    );
  end
endmodule

// File: tb/dual_oneshot_tb.sv
module dual_oneshot_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int CW  = 16;
  localparam int W0  = 5;
  localparam int W1  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] a, b, c;
  logic [NCH*CW-1:0] width;
  logic [NCH-1:0] q, qn;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int    at;
    int    ch;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];

  dual_oneshot #(.NUM_CH(NCH), .CNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_fall_ni(a), .trig_rise_i(b),
    .clr_ni(c), .width_i(width), .pulse_o(q), .pulse_no(qn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs against queued expectations at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          total++;
          if (q[sb[i].ch] !== sb[i].val) begin
            bad++;
            $display("FAIL %s ch%0d cyc %0d: q=%b expected %b",
                     sb[i].tag, sb[i].ch, cyc, q[sb[i].ch], sb[i].val);
          end
          total++;
          if (qn[sb[i].ch] !== ~q[sb[i].ch]) begin
            bad++;
            $display("FAIL R11 ch%0d cyc %0d: qn=%b expected %b",
                     sb[i].ch, cyc, qn[sb[i].ch], ~q[sb[i].ch]);
          end
          sb.delete(i);
        end else if (sb[i].at < cyc) begin
          total++; bad++;
          $display("FAIL %s ch%0d: item for cyc %0d missed, actual none expected %b",
                   sb[i].tag, sb[i].ch, sb[i].at, sb[i].val);
          sb.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int at, int ch, logic val, string tag);
    exp_t e;
    e.at = at; e.ch = ch; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic expect_quiet(int ch, int from, int n, string tag);
    for (int i = 0; i < n; i++) expect_at(cyc + from + i, ch, 1'b0, tag);
  endtask

  task automatic expect_pulse(int ch, int start, int w, string tag);
    for (int i = 0; i < w; i++) expect_at(cyc + start + i, ch, 1'b1, tag);
    expect_at(cyc + start + w, ch, 1'b0, tag);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    a = '1; b = '0; c = '1;
    width = {CW'(W1), CW'(W0)};
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    total++;
    if (q !== '0 || qn !== '1) begin
      bad++;
      $display("FAIL R1: q=%b qn=%b expected q=00 qn=11", q, qn);
    end
    tick(1);

    // R3: rising B while A held high gives nothing
    b[0] = 1'b1; expect_quiet(0, 1, 8, "R3"); tick(8);
    // R5: falling A with B and CLR high
    a[0] = 1'b0; expect_pulse(0, 3, W0, "R5"); tick(10);

    // R4: B low blocks a falling A
    b[0] = 1'b0; expect_quiet(0, 1, 10, "R4");
    tick(1); a[0] = 1'b1; tick(2); a[0] = 1'b0; tick(7);
    // R6: rising B with A low
    b[0] = 1'b1; expect_pulse(0, 3, W0, "R6"); tick(10);

    // R2: clear low masks triggers
    c[0] = 1'b0; expect_quiet(0, 1, 10, "R2");
    tick(1); b[0] = 1'b0; tick(1); b[0] = 1'b1; tick(1);
    a[0] = 1'b1; tick(1); a[0] = 1'b0; tick(6);
    // R7: clear release acts as trigger
    c[0] = 1'b1; expect_pulse(0, 3, W0, "R7"); tick(10);

    // R8: retrigger after pulse started extends it
    b[0] = 1'b0; tick(1); b[0] = 1'b1; t0 = cyc;
    for (int i = 3; i <= 5; i++) expect_at(t0 + i, 0, 1'b1, "R8");
    tick(2); b[0] = 1'b0; tick(1); b[0] = 1'b1;
    expect_pulse(0, 3, W0, "R8"); tick(12);

    // R10: clear in mid-pulse cancels
    b[0] = 1'b0; tick(1); b[0] = 1'b1;
    expect_at(cyc + 3, 0, 1'b1, "R10"); expect_at(cyc + 4, 0, 1'b1, "R10");
    tick(2); c[0] = 1'b0; expect_quiet(0, 3, 4, "R10"); tick(6);
    // R10: clear and trigger edge in the same cycle, clear wins
    b[0] = 1'b0; tick(1); c[0] = 1'b1; tick(4);
    c[0] = 1'b0; b[0] = 1'b1; expect_quiet(0, 1, 10, "R10"); tick(10);
    c[0] = 1'b1; expect_pulse(0, 3, W0, "R7"); tick(10);

    // R9: zero width on channel 1
    width[CW +: CW] = '0;
    a[1] = 1'b0; tick(4);
    b[1] = 1'b1; expect_quiet(1, 1, 10, "R9"); tick(10);

    // R12: channel 1 pulses while channel 0 is cleared, neither disturbs the other
    width[CW +: CW] = CW'(W1);
    a[1] = 1'b1; tick(3);
    a[1] = 1'b0; expect_pulse(1, 3, W1, "R12"); expect_quiet(0, 1, 12, "R12");
    tick(2); c[0] = 1'b0; tick(10);
    c[0] = 1'b1; expect_pulse(0, 3, W0, "R7"); expect_quiet(1, 1, 10, "R12");
    tick(12);

    tick(3);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R12: %0d expectations left, expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule